// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block turns four groups of external interrupt pins into four pending
interrupt flags. Every pin is brought into the clock domain through a two-stage
synchronizer. The synchronized pins of a group are ORed into one group level, and
edges and levels are detected on that level. Each group is judged against a
2-bit sensitivity mode. The four modes are: falling edge with low level, rising
edge only, falling edge only, and both edges.

The modes are held in an 8-bit control register that software writes over a
simple write-enable/data bus. Each mode field is shared by a pair of groups. The
field at bits 4:3 serves groups A (4 pins) and B (3 pins). The field at bits 7:6
serves groups C and D, which are the low and high nibble of one 4+4 pin port.
Software may change the register only while the CPU's global interrupt-disable
flag is set. Software acknowledges a pending flag with a one-cycle clear strobe
per group.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After a synchronous active-low reset the control register reads 8'h00, which selects mode 00 for all groups, and all four pending flags are 0.
- R2: A write with `irq_mask`=1 loads wdata bits 7:6 into the C/D mode field and wdata bits 4:3 into the A/B mode field on the next clock. Bits 5 and 2:0 always read 0.
- R3: A write made while `irq_mask`=0 is ignored, and the register read-back keeps its previous value.
- R4: In mode 00 a group's flag is set on every cycle that its synchronized combined level is low. A falling edge therefore sets it, and a clear strobe cannot keep it cleared while the level stays low.
- R5: In mode 01 only a low-to-high change of the combined level sets the flag.
- R6: In mode 10 only a high-to-low change of the combined level sets the flag.
- R7: In mode 11 both changes of the combined level set the flag.
- R8: A group's pins are ORed before detection. A pin changing while another pin of the same group holds the combined level high produces no event.
- R9: A pin change applied before clock edge k shows on `pend` after edge k+2: two synchronizer stages, then the flag register.
- R10: `pend_clr[g]` clears flag g on the next edge. When an event for group g lands in the same cycle as its clear, the flag stays set. Without an event or a clear, the flag holds.
- R11: The field at bits 4:3 governs groups A and B (pend[0], pend[1]). The field at bits 7:6 governs groups C and D (pend[2], pend[3]). The two pairs can run different modes at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_a | input | 4 | Group A pins (pend[0]) |
| pins_b | input | 3 | Group B pins (pend[1]) |
| pins_c | input | 4 | Group C pins, low nibble of the shared port (pend[2]) |
| pins_d | input | 4 | Group D pins, high nibble of the shared port (pend[3]) |
| irq_mask | input | 1 | Global interrupt-disable flag; 1 permits register writes |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read-back |
| pend_clr | input | 4 | Per-group one-cycle clear strobes |
| pend | output | 4 | Per-group pending flags |

## Verification
The hardest case to reach is an event and its clear strobe landing in the same
cycle. The event appears two clocks after the pin moves, so the bench toggles a
group and raises the clear exactly two cycles later. It also holds a group low in
mode 00 while clearing repeatedly, and it changes one pin while another pin of the
same group stays high. A long seeded random phase then mixes pin changes, clears,
and writes with and without the mask. A cycle model built from the mode table
predicts every flag and the register read-back.

// File: rtl/extint_pkg.sv
// Package: shared mode encoding, register layout and the mode decision for
// the external interrupt sensitivity controller.
package extint_pkg;

    // 2-bit sensitivity mode as software writes it
    typedef enum logic [1:0] {
        SENS_FALL_LOW = 2'b00,
        SENS_RISE     = 2'b01,
        SENS_FALL     = 2'b10,
        SENS_BOTH     = 2'b11
    } sens_mode_e;

    localparam int CTRL_W     = 8;
    localparam int MODE_W     = 2;
    localparam int FLD_LO_LSB = 3;   // field for groups A/B
    localparam int FLD_HI_LSB = 6;   // field for groups C/D
    localparam int NUM_GRP    = 4;

    // Decide whether the current/previous synchronized levels form an event
    function automatic logic sens_hit(sens_mode_e mode, logic cur, logic prv);
        logic hit;
        unique case (mode)
            SENS_FALL_LOW: hit = ~cur;
            SENS_RISE:     hit = cur & ~prv;
            SENS_FALL:     hit = ~cur & prv;
            default:       hit = cur ^ prv;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/extint_sync.sv
// Two-stage synchronizer for a vector of asynchronous pins.
// Assumes pins are quasi-static relative to clk; each bit is synchronized
// independently. Both stages reset to RST_VAL (idle-high pins by default).
module extint_sync #(
    parameter int WIDTH = 4,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the pins through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= {WIDTH{RST_VAL}};
            stage2_q <= {WIDTH{RST_VAL}};
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;

endmodule

// File: rtl/extint_cfg_reg.sv
// Control register holding the two sensitivity fields.
// Assumes a single-address write port; writes land only while the global
// interrupt-disable flag is 1. Non-field bits are not stored and read 0.
module extint_cfg_reg
    import extint_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              irq_mask,
    output sens_mode_e        mode_lo,
    output sens_mode_e        mode_hi,
    output logic [CTRL_W-1:0] rdata
);

    // Load both fields on a write permitted by the mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_lo <= SENS_FALL_LOW;
            mode_hi <= SENS_FALL_LOW;
        end else if (wr_en && irq_mask) begin
            mode_lo <= sens_mode_e'(wdata[FLD_LO_LSB +: MODE_W]);
            mode_hi <= sens_mode_e'(wdata[FLD_HI_LSB +: MODE_W]);
        end
    end

    // Assemble the read-back image with spare bits at zero
    always_comb begin
        rdata = '0;
        rdata[FLD_LO_LSB +: MODE_W] = mode_lo;
        rdata[FLD_HI_LSB +: MODE_W] = mode_hi;
    end

endmodule

// File: rtl/extint_group.sv
// One interrupt group: synchronize pins, OR them into a group level, detect
// the event selected by the mode, and keep a pending flag.
// Assumes clr is a one-cycle strobe; a new event outranks a clear.
module extint_group
    import extint_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    input  sens_mode_e       mode,
    input  logic             clr,
    output logic             evt,
    output logic             lvl,
    output logic             pend
);

    logic [WIDTH-1:0] pins_s;
    logic             lvl_q;

    extint_sync #(
        .WIDTH   (WIDTH),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins),
        .dout  (pins_s)
    );

    // Combine the synchronized pins into one group level
    assign lvl = |pins_s;

    // Remember the previous group level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl;
    end

    // Decide whether this cycle carries an event for the current mode
    assign evt = sens_hit(mode, lvl, lvl_q);

    // Pending flag: set by event, cleared by strobe, set dominates
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= 1'b0;
        else if (evt) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end

endmodule

// File: rtl/extint_sense_ctrl.sv
// Top: four interrupt groups sharing two sensitivity fields pairwise.
// Groups 0/1 (A/B) follow the field at bits 4:3, groups 2/3 (C/D) the field
// at bits 7:6. Assumes pins are asynchronous and the clear strobes synchronous.
module extint_sense_ctrl
    import extint_pkg::*;
#(
    parameter int GA_W = 4,
    parameter int GB_W = 3,
    parameter int GC_W = 4,
    parameter int GD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GA_W-1:0]    pins_a,
    input  logic [GB_W-1:0]    pins_b,
    input  logic [GC_W-1:0]    pins_c,
    input  logic [GD_W-1:0]    pins_d,
    input  logic               irq_mask,
    input  logic               reg_wr_en,
    input  logic [CTRL_W-1:0]  reg_wdata,
    output logic [CTRL_W-1:0]  reg_rdata,
    input  logic [NUM_GRP-1:0] pend_clr,
    output logic [NUM_GRP-1:0] pend
);

    localparam int PIN_TOT = GA_W + GB_W + GC_W + GD_W;

    // Width of group g
    function automatic int grp_w(int g);
        case (g)
            0:       return GA_W;
            1:       return GB_W;
            2:       return GC_W;
            default: return GD_W;
        endcase
    endfunction

    // Bit offset of group g in the flat pin vector
    function automatic int grp_off(int g);
        int o;
        o = 0;
        for (int i = 0; i < g; i++) o += grp_w(i);
        return o;
    endfunction

    logic [PIN_TOT-1:0] pins_all;
    sens_mode_e         mode_lo;
    sens_mode_e         mode_hi;
    logic [NUM_GRP-1:0] grp_evt;
    logic [NUM_GRP-1:0] grp_lvl;

    // Flatten the group pin ports, group 0 at the bottom
    assign pins_all = {pins_d, pins_c, pins_b, pins_a};

    extint_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wdata    (reg_wdata),
        .irq_mask (irq_mask),
        .mode_lo  (mode_lo),
        .mode_hi  (mode_hi),
        .rdata    (reg_rdata)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int W = grp_w(g);
        localparam int O = grp_off(g);
        sens_mode_e grp_mode;

        // Pick the shared field for this group's pair
        if (g < NUM_GRP / 2) begin : g_lo
            assign grp_mode = mode_lo;
        end else begin : g_hi
            assign grp_mode = mode_hi;
        end

        extint_group #(
            .WIDTH (W)
        ) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .pins  (pins_all[O +: W]),
            .mode  (grp_mode),
            .clr   (pend_clr[g]),
            .evt   (grp_evt[g]),
            .lvl   (grp_lvl[g]),
            .pend  (pend[g])
        );
    end

endmodule

// File: rtl/extint_sense_ctrl_chk.sv
// Checker for extint_sense_ctrl: register write rules, flag set/clear
// priority and level-mode stickiness. Bound to every instance of the top.
module extint_sense_ctrl_chk
    import extint_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               irq_mask,
    input logic               reg_wr_en,
    input logic [CTRL_W-1:0]  reg_wdata,
    input logic [CTRL_W-1:0]  reg_rdata,
    input logic [NUM_GRP-1:0] pend_clr,
    input logic [NUM_GRP-1:0] pend,
    input logic [NUM_GRP-1:0] grp_evt,
    input logic [NUM_GRP-1:0] grp_lvl,
    input sens_mode_e         mode_lo,
    input sens_mode_e         mode_hi
);

    a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5] == 1'b0 && reg_rdata[2:0] == 3'b000);

    a_r2_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && irq_mask) |=>
            (reg_rdata[7:6] == $past(reg_wdata[7:6]) &&
             reg_rdata[4:3] == $past(reg_wdata[4:3])));

    a_r3_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && irq_mask) |=> $stable(reg_rdata));

    a_r10_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_evt != '0) |=> ((pend & $past(grp_evt)) == $past(grp_evt)));

    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr & ~grp_evt) != '0 |=>
            ((pend & $past(pend_clr & ~grp_evt)) == '0));

    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~pend_clr) != '0 |=>
            ((pend & $past(pend & ~pend_clr)) == $past(pend & ~pend_clr)));

    a_r4_low_sticks_a: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_lo == SENS_FALL_LOW && !grp_lvl[0]) |=> pend[0]);

    a_r4_low_sticks_c: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hi == SENS_FALL_LOW && !grp_lvl[2]) |=> pend[2]);

    a_r5_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_lo == SENS_RISE && grp_evt[1]) |-> (grp_lvl[1] && !$past(grp_lvl[1])));

    a_r6_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_hi == SENS_FALL && grp_evt[3]) |-> (!grp_lvl[3] && $past(grp_lvl[3])));

endmodule

bind extint_sense_ctrl extint_sense_ctrl_chk chk_i (.*);

// File: tb/extint_sense_ctrl_tb_top.sv
module extint_sense_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pins_a;
    logic [2:0] pins_b;
    logic [3:0] pins_c;
    logic [3:0] pins_d;
    logic       irq_mask;
    logic       reg_wr_en;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [3:0] pend_clr;
    logic [3:0] pend;

    always #5 clk = ~clk;

    extint_sense_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_a    (pins_a),
        .pins_b    (pins_b),
        .pins_c    (pins_c),
        .pins_d    (pins_d),
        .irq_mask  (irq_mask),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pend_clr  (pend_clr),
        .pend      (pend)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";

    // Reference state: applied combined levels per group, newest first
    bit         hist [4][4];
    logic [3:0] m_pend;
    logic [7:0] m_reg;

    // Event rule taken from the mode table
    function automatic bit ev_f(logic [1:0] md, bit cur, bit prv);
        case (md)
            2'b00:   return !cur;
            2'b01:   return cur && !prv;
            2'b10:   return !cur && prv;
            default: return cur != prv;
        endcase
    endfunction

    function automatic bit comb_f(int g);
        case (g)
            0:       return |pins_a;
            1:       return |pins_b;
            2:       return |pins_c;
            default: return |pins_d;
        endcase
    endfunction

    task automatic chk(string t, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    // One clock: advance the model with the held inputs, then compare
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        for (int g = 0; g < 4; g++) begin
            logic [1:0] md;
            hist[g][3] = hist[g][2];
            hist[g][2] = hist[g][1];
            hist[g][1] = hist[g][0];
            hist[g][0] = comb_f(g);
            md = (g < 2) ? m_reg[4:3] : m_reg[7:6];
            m_pend[g] = ev_f(md, hist[g][2], hist[g][3]) | (m_pend[g] & ~pend_clr[g]);
        end
        if (reg_wr_en && irq_mask) m_reg = reg_wdata & 8'hD8;
        chk(tag, "pend", {4'h0, pend}, {4'h0, m_pend});
        chk(tag, "rdata", reg_rdata, m_reg);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [7:0] d, logic msk);
        irq_mask  = msk;
        reg_wr_en = 1'b1;
        reg_wdata = d;
        step();
        reg_wr_en = 1'b0;
        irq_mask  = 1'b0;
    endtask

    task automatic clr_all();
        pend_clr = 4'hF;
        step();
        pend_clr = 4'h0;
    endtask

    task automatic idle_hi();
        pins_a = '1; pins_b = '1; pins_c = '1; pins_d = '1;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_mask = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
        pend_clr = '0;
        idle_hi();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int g = 0; g < 4; g++)
            for (int k = 0; k < 4; k++) hist[g][k] = 1'b1;
        m_pend = '0;
        m_reg  = '0;

        // R1: reset state, pins idle high in mode 00
        tag = "R1";
        chk(tag, "rdata", reg_rdata, 8'h00);
        chk(tag, "pend", {4'h0, pend}, 8'h00);
        run(4);

        // R2: masked write fills both fields, spare bits read zero
        tag = "R2";
        wr(8'hFF, 1'b1);
        run(2);
        chk(tag, "rdata_direct", reg_rdata, 8'hD8);

        // R3: unmasked write leaves the register alone
        tag = "R3";
        wr(8'h00, 1'b0);
        run(2);
        chk(tag, "rdata_direct", reg_rdata, 8'hD8);

        // R7: both edges in mode 11
        tag = "R7";
        pins_a = 4'h0; run(5);
        chk(tag, "pend_a_fall", {7'h0, pend[0]}, 8'h01);
        clr_all();
        pins_a = 4'h5; run(5);
        chk(tag, "pend_a_rise", {7'h0, pend[0]}, 8'h01);
        clr_all(); run(2);

        // R9: latency of a pin change to the flag
        tag = "R9";
        pins_b = 3'b000;
        step(); step();
        chk(tag, "pend_b_early", {7'h0, pend[1]}, 8'h00);
        step();
        chk(tag, "pend_b_third", {7'h0, pend[1]}, 8'h01);
        pins_b = 3'b111; run(4); clr_all(); run(2);

        // R5: rise only
        tag = "R5";
        wr(8'h48, 1'b1);
        pins_b = 3'b000; run(5);
        chk(tag, "pend_b_fall_ignored", {7'h0, pend[1]}, 8'h00);
        pins_b = 3'b010; run(5);
        chk(tag, "pend_b_rise", {7'h0, pend[1]}, 8'h01);
        clr_all(); run(2);

        // R6: fall only
        tag = "R6";
        wr(8'h90, 1'b1);
        pins_c = 4'h0; run(5);
        chk(tag, "pend_c_fall", {7'h0, pend[2]}, 8'h01);
        clr_all();
        pins_c = 4'h8; run(5);
        chk(tag, "pend_c_rise_ignored", {7'h0, pend[2]}, 8'h00);

        // R11: pairs in different modes (A/B fall, C/D rise)
        tag = "R11";
        wr(8'h50, 1'b1);
        pins_a = 4'h0; pins_b = 3'h0; pins_c = 4'h0; pins_d = 4'h0; run(5);
        chk(tag, "pend_after_fall", {4'h0, pend}, 8'h03);
        clr_all();
        idle_hi(); run(5);
        chk(tag, "pend_after_rise", {4'h0, pend}, 8'h0C);
        clr_all(); run(2);

        // R8: OR combining hides a pin swap within a group
        tag = "R8";
        wr(8'hD8, 1'b1);
        pins_d = 4'b0001; run(5);
        chk(tag, "pend_d_still_high", {7'h0, pend[3]}, 8'h00);
        pins_d = 4'b0010; run(5);
        chk(tag, "pend_d_swap", {7'h0, pend[3]}, 8'h00);
        idle_hi(); run(3);

        // R4: low level keeps the flag up through clears
        tag = "R4";
        wr(8'h00, 1'b1);
        pins_a = 4'h0; run(4);
        pend_clr = 4'h1; run(3); pend_clr = 4'h0;
        chk(tag, "pend_a_sticky", {7'h0, pend[0]}, 8'h01);
        pins_a = 4'hF; run(3);
        clr_all(); run(1);
        chk(tag, "pend_a_cleared", {7'h0, pend[0]}, 8'h00);

        // R10: event and clear in the same cycle, then a lone clear
        tag = "R10";
        wr(8'hD8, 1'b1);
        pins_b = 3'b000;
        step(); step();
        pend_clr = 4'h2; step(); pend_clr = 4'h0;
        chk(tag, "pend_b_set_wins", {7'h0, pend[1]}, 8'h01);
        run(2);
        chk(tag, "pend_b_holds", {7'h0, pend[1]}, 8'h01);
        pend_clr = 4'h2; step(); pend_clr = 4'h0;
        chk(tag, "pend_b_cleared", {7'h0, pend[1]}, 8'h00);
        pins_b = 3'b111; run(4); clr_all();

        // R9: seeded random mix of pins, clears and writes
        tag = "R9";
        void'($urandom(32'h5EED));
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(3) == 0) pins_a = $urandom_range(1) ? 4'h0 : 4'($urandom);
            if ($urandom_range(3) == 0) pins_b = $urandom_range(1) ? 3'h0 : 3'($urandom);
            if ($urandom_range(3) == 0) pins_c = $urandom_range(1) ? 4'h0 : 4'($urandom);
            if ($urandom_range(3) == 0) pins_d = $urandom_range(1) ? 4'h0 : 4'($urandom);
            pend_clr  = ($urandom_range(2) == 0) ? 4'($urandom) : 4'h0;
            reg_wr_en = ($urandom_range(15) == 0);
            irq_mask  = 1'($urandom);
            reg_wdata = 8'($urandom);
            step();
        end
        reg_wr_en = 1'b0;
        pend_clr  = '0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule